// File: doc/BRIEF.md
# Time-Aware Egress Gate Scheduler

This block opens and closes the eight per-class transmit gates of one switch egress port according to a repeating gate list. Each list entry pairs an 8-bit gate mask with a hold time in nanoseconds. Time comes from a free-running 64-bit nanosecond counter that a PTP servo keeps aligned to the network. The counter is an input and is not part of this block.

Software writes the entries, the number of valid entries, a 64-bit base time and an optional cycle time through a small write port, then raises the enable input. If no cycle time is given, the cycle length is the sum of the valid entry durations. If the base time already lies in the past, the first cycle starts at the nearest later instant that is a whole number of cycles after the base. That instant is found by a bit-serial remainder unit. Until the start instant all gates are open. After it, the entries play in list order, and the list restarts at entry 0 at every cycle boundary.

A time step larger than one cycle, forward or backward, makes the block drop its position and recompute the start from the base time. The current entry index and a one-cycle boundary pulse are brought out so the schedule can be observed.

Top module: `tas_gate_sched`

## Requirements
- R1: While the schedule runs, `gate_o` equals the mask of the current entry, and bit i of the mask opens traffic class i. A mask of 0x80 opens class 7 only, 0x40 opens class 6 only, and 0x3f opens classes 0 to 5. `entry_idx_o` is the index of that entry and is always below the valid-entry count.
- R2: Entries play in list order. Entry i is active from the point where the durations of entries 0 to i-1 have elapsed in the cycle. At every cycle boundary the list restarts at entry 0, and `cycle_start_o` is high for exactly the one clock in which entry 0 is entered.
- R3: When the cycle-time register holds zero, the cycle length is the sum of the durations of the valid entries. For example, 50000, 50000 and 300000 ns give 400000 ns.
- R4: The start instant S is computed from the time value sampled on the clock after enable. If the base B is at or after that time, S = B. Otherwise S = B + k·C, with k the smallest integer that gives S at or after the sampled time. This includes the case where the sampled time is itself a boundary.
- R5: From enable until S, `gate_o` is 0xFF. `busy_o` is high while S is being computed, and `gate_o` is 0xFF whenever `busy_o` is high. Entry 0's mask appears on the clock edge at which the time input first reaches S.
- R6: With a valid-entry count of zero, `gate_o` stays 0xFF, `entry_idx_o` stays 0, and no boundary pulse and no computation occur.
- R7: A nonzero cycle-time register sets the cycle length directly. If it is longer than the entry sum, the last entry's mask is held until the boundary. If it is shorter, the entries are cut off at the boundary.
- R8: A time input that lies more than one cycle past the end of the current entry, or more than one cycle before that entry's start, makes the block recompute S from the base using that time, with `busy_o` high and gates open. The schedule then resumes in phase with the base.
- R9: Register writes made while enable is high are ignored.
- R10: After reset, and on the clock after enable goes low, `gate_o` is 0xFF, `entry_idx_o` is 0, and `cycle_start_o` and `busy_o` are low.
- R11: The register map, with word addresses and 32-bit data, is: 0 to 7 are the duration of entries 0 to 7; 8 to 15 are the masks of entries 0 to 7 in bits 7:0; 16 is the valid-entry count in bits 3:0, where values above 8 act as 8; 17 is base time bits 31:0; 18 is base time bits 63:32; 19 is the cycle time (0 means derive it).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable_i | input | 1 | Run the schedule; low forces all gates open |
| now_ns_i | input | 64 | Disciplined nanosecond time |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 5 | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| gate_o | output | 8 | Gate-open vector, bit i for class i |
| entry_idx_o | output | 3 | Index of the active entry |
| cycle_start_o | output | 1 | One-clock pulse at each cycle boundary |
| busy_o | output | 1 | Start-time computation in progress |

## Verification
Two events can coincide: the last entry's end and the cycle boundary fall on the same time value whenever the cycle length is derived from the entry sum. The boundary must win, so that the index returns to 0 with a pulse and does not stall on the last entry. The bench provokes this by stepping time in 1000 ns increments from a start that is a multiple of 1000, so that entry ends and boundaries land exactly on sampled values. It judges every clock against a model that takes the entry and cycle from the time's phase. Forward and backward jumps then test recomputation against the same model.

// File: rtl/tas_pkg.sv
package tas_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF,
        SEQ_CALC,
        SEQ_WAIT,
        SEQ_RUN
    } seq_state_e;

    typedef enum logic [1:0] {
        CALC_IDLE,
        CALC_DIV,
        CALC_DONE
    } calc_state_e;

endpackage

// File: rtl/tas_cfg_regs.sv
module tas_cfg_regs #(
    parameter int MAX_ENT = 8,
    parameter int NUM_TC  = 8,
    parameter int DUR_W   = 32,
    parameter int TIME_W  = 64,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5,
    localparam int CNT_W  = $clog2(MAX_ENT + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              lock_i,
    input  logic                              we_i,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [DATA_W-1:0]                 wdata_i,
    output logic [MAX_ENT-1:0][DUR_W-1:0]     dur_o,
    output logic [MAX_ENT-1:0][NUM_TC-1:0]    mask_o,
    output logic [CNT_W-1:0]                  count_o,
    output logic [TIME_W-1:0]                 base_o,
    output logic [DUR_W-1:0]                  cycle_o
);

    localparam int A_MASK  = MAX_ENT;
    localparam int A_COUNT = 2 * MAX_ENT;
    localparam int A_BLO   = A_COUNT + 1;
    localparam int A_BHI   = A_COUNT + 2;
    localparam int A_CYC   = A_COUNT + 3;
    localparam int SUM_W   = DUR_W + CNT_W;

    typedef struct packed {
        logic [MAX_ENT-1:0][DUR_W-1:0]  dur;
        logic [MAX_ENT-1:0][NUM_TC-1:0] mask;
        logic [CNT_W-1:0]               count;
        logic [TIME_W-1:0]              base;
        logic [DUR_W-1:0]               cyc;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_ok;
    logic [MAX_ENT-1:0] hit_dur, hit_mask;
    logic [SUM_W-1:0] sum;

    assign wr_ok = we_i && !lock_i;

    for (genvar g = 0; g < MAX_ENT; g++) begin : g_hit
        assign hit_dur[g]  = wr_ok && (addr_i == ADDR_W'(g));
        assign hit_mask[g] = wr_ok && (addr_i == ADDR_W'(A_MASK + g));
    end

    always_comb begin
        cfg_d = cfg_q;
        for (int i = 0; i < MAX_ENT; i++) begin
            if (hit_dur[i])  cfg_d.dur[i]  = wdata_i[DUR_W-1:0];
            if (hit_mask[i]) cfg_d.mask[i] = wdata_i[NUM_TC-1:0];
        end
        if (wr_ok) begin
            if (addr_i == ADDR_W'(A_COUNT)) begin
                if (wdata_i[CNT_W-1:0] > CNT_W'(MAX_ENT)) cfg_d.count = CNT_W'(MAX_ENT);
                else                                      cfg_d.count = wdata_i[CNT_W-1:0];
            end
            if (addr_i == ADDR_W'(A_BLO)) cfg_d.base[DATA_W-1:0]      = wdata_i;
            if (addr_i == ADDR_W'(A_BHI)) cfg_d.base[TIME_W-1:DATA_W] = wdata_i[TIME_W-DATA_W-1:0];
            if (addr_i == ADDR_W'(A_CYC)) cfg_d.cyc                   = wdata_i[DUR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{dur: '0, mask: '1, count: '0, base: '0, cyc: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < MAX_ENT; i++) begin
            if (CNT_W'(i) < cfg_q.count) sum = sum + SUM_W'(cfg_q.dur[i]);
        end
    end

    assign dur_o   = cfg_q.dur;
    assign mask_o  = cfg_q.mask;
    assign count_o = cfg_q.count;
    assign base_o  = cfg_q.base;
    assign cycle_o = (cfg_q.cyc != '0) ? cfg_q.cyc : sum[DUR_W-1:0];

endmodule

// File: rtl/tas_start_calc.sv
module tas_start_calc
    import tas_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int DUR_W  = 32,
    localparam int CNT_W = $clog2(TIME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_i,
    input  logic              go_i,
    input  logic [TIME_W-1:0] now_i,
    input  logic [TIME_W-1:0] base_i,
    input  logic [DUR_W-1:0]  cycle_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [TIME_W-1:0] start_o
);

    typedef struct packed {
        calc_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic [TIME_W-1:0] diff;
        logic [TIME_W-1:0] snap;
        logic [TIME_W-1:0] start;
        logic [DUR_W:0]    rem;
        logic [DUR_W-1:0]  cyc;
    } calc_t;

    calc_t c_d, c_q;
    logic [DUR_W:0] rem_sh;

    always_comb begin
        c_d    = c_q;
        rem_sh = {c_q.rem[DUR_W-1:0], c_q.diff[TIME_W-1]};
        if (abort_i) begin
            c_d.st = CALC_IDLE;
        end else begin
            case (c_q.st)
                CALC_IDLE: begin
                    if (go_i) begin
                        c_d.snap = now_i;
                        c_d.cyc  = cycle_i;
                        c_d.rem  = '0;
                        c_d.cnt  = CNT_W'(TIME_W);
                        if (base_i >= now_i) begin
                            c_d.start = base_i;
                            c_d.st    = CALC_DONE;
                        end else begin
                            c_d.diff = now_i - base_i;
                            c_d.st   = CALC_DIV;
                        end
                    end
                end
                CALC_DIV: begin
                    if (c_q.cnt != '0) begin
                        c_d.rem  = (rem_sh >= {1'b0, c_q.cyc}) ? rem_sh - {1'b0, c_q.cyc} : rem_sh;
                        c_d.diff = c_q.diff << 1;
                        c_d.cnt  = c_q.cnt - 1'b1;
                    end else begin
                        c_d.start = (c_q.rem == '0) ? c_q.snap
                                  : c_q.snap + TIME_W'(c_q.cyc) - TIME_W'(c_q.rem);
                        c_d.st    = CALC_DONE;
                    end
                end
                CALC_DONE: c_d.st = CALC_IDLE;
                default:   c_d.st = CALC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: CALC_IDLE, cnt: '0, diff: '0, snap: '0, start: '0, rem: '0, cyc: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign busy_o  = (c_q.st != CALC_IDLE);
    assign done_o  = (c_q.st == CALC_DONE);
    assign start_o = c_q.start;

endmodule

// File: rtl/tas_gate_seq.sv
module tas_gate_seq
    import tas_pkg::*;
#(
    parameter int MAX_ENT = 8,
    parameter int NUM_TC  = 8,
    parameter int DUR_W   = 32,
    parameter int TIME_W  = 64,
    localparam int IDX_W  = $clog2(MAX_ENT),
    localparam int CNT_W  = $clog2(MAX_ENT + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           enable_i,
    input  logic [TIME_W-1:0]              now_i,
    input  logic [MAX_ENT-1:0][DUR_W-1:0]  dur_i,
    input  logic [MAX_ENT-1:0][NUM_TC-1:0] mask_i,
    input  logic [CNT_W-1:0]               count_i,
    input  logic [DUR_W-1:0]               cycle_i,
    input  logic                           done_i,
    input  logic [TIME_W-1:0]              start_i,
    output logic                           go_o,
    output logic [NUM_TC-1:0]              gate_o,
    output logic [IDX_W-1:0]               idx_o,
    output logic                           pulse_o
);

    typedef struct packed {
        seq_state_e        st;
        logic [NUM_TC-1:0] gate;
        logic [IDX_W-1:0]  idx;
        logic              pulse;
        logic [TIME_W-1:0] start;
        logic [TIME_W-1:0] ent_start;
        logic [TIME_W-1:0] ent_end;
        logic [TIME_W-1:0] cyc_end;
    } seq_t;

    localparam seq_t SEQ_RESET = '{st: SEQ_OFF, gate: '1, idx: '0, pulse: 1'b0,
                                   start: '0, ent_start: '0, ent_end: '0, cyc_end: '0};

    seq_t s_d, s_q;
    logic [TIME_W-1:0] cyc_w, ref_end;
    logic [IDX_W-1:0]  last, nxt;
    logic              jump;

    always_comb begin
        s_d     = s_q;
        s_d.pulse = 1'b0;
        go_o    = 1'b0;
        cyc_w   = TIME_W'(cycle_i);
        last    = IDX_W'(count_i - 1'b1);
        nxt     = s_q.idx + 1'b1;
        ref_end = (s_q.idx == last) ? s_q.cyc_end : s_q.ent_end;
        jump    = (now_i >= ref_end + cyc_w) || ((now_i + cyc_w) < s_q.ent_start);
        if (!enable_i) begin
            s_d = SEQ_RESET;
        end else begin
            case (s_q.st)
                SEQ_OFF: begin
                    if (count_i != '0 && cycle_i != '0) begin
                        go_o   = 1'b1;
                        s_d.st = SEQ_CALC;
                    end
                end
                SEQ_CALC: begin
                    if (done_i) begin
                        s_d.start = start_i;
                        s_d.st    = SEQ_WAIT;
                    end
                end
                SEQ_WAIT: begin
                    if (now_i >= s_q.start) begin
                        s_d.st        = SEQ_RUN;
                        s_d.idx       = '0;
                        s_d.gate      = mask_i[0];
                        s_d.pulse     = 1'b1;
                        s_d.ent_start = s_q.start;
                        s_d.ent_end   = s_q.start + TIME_W'(dur_i[0]);
                        s_d.cyc_end   = s_q.start + cyc_w;
                    end
                end
                SEQ_RUN: begin
                    if (jump) begin
                        go_o     = 1'b1;
                        s_d.st   = SEQ_CALC;
                        s_d.gate = '1;
                        s_d.idx  = '0;
                    end else if (now_i >= s_q.cyc_end) begin
                        s_d.idx       = '0;
                        s_d.gate      = mask_i[0];
                        s_d.pulse     = 1'b1;
                        s_d.ent_start = s_q.cyc_end;
                        s_d.ent_end   = s_q.cyc_end + TIME_W'(dur_i[0]);
                        s_d.cyc_end   = s_q.cyc_end + cyc_w;
                    end else if (now_i >= s_q.ent_end && s_q.idx != last) begin
                        s_d.idx       = nxt;
                        s_d.gate      = mask_i[nxt];
                        s_d.ent_start = s_q.ent_end;
                        s_d.ent_end   = s_q.ent_end + TIME_W'(dur_i[nxt]);
                    end
                end
                default: s_d = SEQ_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SEQ_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign gate_o  = s_q.gate;
    assign idx_o   = s_q.idx;
    assign pulse_o = s_q.pulse;

endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched #(
    parameter int MAX_ENT = 8,
    parameter int NUM_TC  = 8,
    parameter int DUR_W   = 32,
    parameter int TIME_W  = 64,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5,
    localparam int IDX_W  = $clog2(MAX_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [TIME_W-1:0] now_ns_i,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic [NUM_TC-1:0] gate_o,
    output logic [IDX_W-1:0]  entry_idx_o,
    output logic              cycle_start_o,
    output logic              busy_o
);

    localparam int CNT_W = $clog2(MAX_ENT + 1);

    logic [MAX_ENT-1:0][DUR_W-1:0]  cfg_dur;
    logic [MAX_ENT-1:0][NUM_TC-1:0] cfg_mask;
    logic [CNT_W-1:0]               cfg_count;
    logic [TIME_W-1:0]              cfg_base;
    logic [DUR_W-1:0]               cfg_cycle;
    logic                           calc_go, calc_done;
    logic [TIME_W-1:0]              calc_start;

    tas_cfg_regs #(
        .MAX_ENT(MAX_ENT), .NUM_TC(NUM_TC), .DUR_W(DUR_W),
        .TIME_W(TIME_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_i  (enable_i),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .dur_o   (cfg_dur),
        .mask_o  (cfg_mask),
        .count_o (cfg_count),
        .base_o  (cfg_base),
        .cycle_o (cfg_cycle)
    );

    tas_start_calc #(
        .TIME_W(TIME_W), .DUR_W(DUR_W)
    ) u_calc (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort_i (!enable_i),
        .go_i    (calc_go),
        .now_i   (now_ns_i),
        .base_i  (cfg_base),
        .cycle_i (cfg_cycle),
        .busy_o  (busy_o),
        .done_o  (calc_done),
        .start_o (calc_start)
    );

    tas_gate_seq #(
        .MAX_ENT(MAX_ENT), .NUM_TC(NUM_TC), .DUR_W(DUR_W), .TIME_W(TIME_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .now_i    (now_ns_i),
        .dur_i    (cfg_dur),
        .mask_i   (cfg_mask),
        .count_i  (cfg_count),
        .cycle_i  (cfg_cycle),
        .done_i   (calc_done),
        .start_i  (calc_start),
        .go_o     (calc_go),
        .gate_o   (gate_o),
        .idx_o    (entry_idx_o),
        .pulse_o  (cycle_start_o)
    );

endmodule

// File: rtl/tas_gate_sched_chk.sv
module tas_gate_sched_chk #(
    parameter int NUM_TC = 8,
    parameter int IDX_W  = 3,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              busy,
    input logic [NUM_TC-1:0] gate,
    input logic [IDX_W-1:0]  idx,
    input logic              pulse,
    input logic [CNT_W-1:0]  count
);

    assert_open_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (gate == {NUM_TC{1'b1}}));

    assert_pulse_on_entry0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (idx == '0 && !busy));

    assert_open_after_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (gate == {NUM_TC{1'b1}} && idx == '0 && !pulse));

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> $stable(count));

    assert_idx_below_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |-> (CNT_W'(idx) < count));

    assert_empty_list_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (gate == {NUM_TC{1'b1}} && !pulse));

endmodule

bind tas_gate_sched tas_gate_sched_chk #(
    .NUM_TC(NUM_TC), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable_i),
    .busy   (busy_o),
    .gate   (gate_o),
    .idx    (entry_idx_o),
    .pulse  (cycle_start_o),
    .count  (cfg_count)
);

// File: tb/tas_gate_sched_tb_top.sv
`timescale 1ns/1ps
module tas_gate_sched_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [63:0] now = 64'd0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  gate;
    logic [2:0]  idx;
    logic        pulse;
    logic        busy;

    int vecs = 0;
    int miss = 0;

    longint     m_dur [8];
    logic [7:0] m_msk [8];
    int         m_cnt;
    longint     m_cyc, m_base, m_start, m_last_cyc;
    bit         m_fresh;

    always #10 clk = ~clk;

    tas_gate_sched dut_i (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .now_ns_i(now),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .gate_o(gate), .entry_idx_o(idx), .cycle_start_o(pulse), .busy_o(busy)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vecs++;
        if (!ok) begin
            miss++;
            $display("FAIL %s: actual %0h expected %0h at time-in %0d", req, act, exp, now);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input longint d);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d[31:0];
        tick();
        cfg_we = 1'b0;
    endtask

    function automatic longint calc_start(input longint b, input longint n, input longint c);
        longint r;
        if (b >= n) return b;
        r = (n - b) % c;
        return (r == 0) ? n : n + c - r;
    endfunction

    // R11 map: 0..7 durations, 8..15 masks, 16 count, 17/18 base, 19 cycle
    task automatic load(input int cnt, input longint cyc, input longint base);
        longint sum = 0;
        for (int i = 0; i < 8; i++) wr(i, m_dur[i]);
        for (int i = 0; i < 8; i++) wr(8 + i, {56'd0, m_msk[i]});
        wr(16, cnt);
        wr(17, base & 64'hFFFF_FFFF);
        wr(18, base >> 32);
        wr(19, cyc);
        for (int i = 0; i < cnt; i++) sum += m_dur[i];
        m_cnt  = cnt;
        m_cyc  = (cyc != 0) ? cyc : sum;
        m_base = base;
    endtask

    task automatic set_ref();
        m_dur[0] = 50000;  m_msk[0] = 8'h80;
        m_dur[1] = 50000;  m_msk[1] = 8'h40;
        m_dur[2] = 300000; m_msk[2] = 8'h3f;
        for (int i = 3; i < 8; i++) begin m_dur[i] = 1000; m_msk[i] = 8'h01; end
    endtask

    // time is held while the start instant is computed; gates must stay open
    task automatic hold_calc(input string req);
        tick();
        chk(busy == 1'b1, {req, " busy raised"}, busy, 1);
        chk(gate == 8'hFF, "R5 gates open at calc start", gate, 8'hFF);
        for (int k = 0; k < 100 && busy; k++) begin
            tick();
            chk(gate == 8'hFF, "R5 gates open while busy", gate, 8'hFF);
        end
        chk(busy == 1'b0, {req, " busy cleared"}, busy, 0);
        m_start = calc_start(m_base, now, m_cyc);
        m_fresh = 1'b1;
    endtask

    task automatic run_cmp(input int n, input longint step, input string req);
        for (int k = 0; k < n; k++) begin
            longint t, ph, acc, cn;
            logic [7:0] eg;
            int ei;
            bit ep;
            tick();
            t = now;
            if (t < m_start) begin
                eg = 8'hFF; ei = 0; ep = 1'b0;
            end else begin
                ph = (t - m_start) % m_cyc;
                cn = (t - m_start) / m_cyc;
                acc = 0; ei = m_cnt - 1;
                for (int i = 0; i < m_cnt; i++) begin
                    acc += m_dur[i];
                    if (ph < acc) begin ei = i; break; end
                end
                eg = m_msk[ei];
                ep = m_fresh || (cn != m_last_cyc);
                m_fresh = 1'b0;
                m_last_cyc = cn;
            end
            chk(gate == eg, {req, " gate"}, gate, eg);
            chk(idx == 3'(ei), {req, " index"}, idx, ei);
            chk(pulse == ep, {req, " boundary pulse"}, pulse, ep);
            now = now + 64'(step);
        end
    endtask

    task automatic do_disable();
        enable = 1'b0;
        tick();
        chk(gate == 8'hFF && idx == 0 && !pulse && !busy, "R10 idle after disable",
            {gate, 5'(idx), pulse, busy}, {8'hFF, 5'd0, 2'b00});
    endtask

    task automatic t_reset();
        tick();
        chk(gate == 8'hFF, "R10 reset gate", gate, 8'hFF);
        chk(idx == 0 && !pulse && !busy, "R10 reset idle", {idx, pulse, busy}, 0);
    endtask

    // R1 R2 R3 R4: derived cycle, base in the past, exact edge landings
    task automatic t_reference();
        set_ref();
        load(3, 0, 0);
        now = 64'd1_000_000;
        enable = 1'b1;
        hold_calc("R4");
        chk(m_start == 1_200_000, "R3 derived cycle start", m_start, 1_200_000);
        run_cmp(1100, 1000, "R1 R2 reference");
    endtask

    // R4 with a non-aligned sample time
    task automatic t_unaligned();
        do_disable();
        load(3, 0, 0);
        now = 64'd1_000_123;
        enable = 1'b1;
        hold_calc("R4");
        run_cmp(700, 1000, "R4 unaligned");
    endtask

    // R4 and R5: sampled time lands on a boundary
    task automatic t_on_boundary();
        do_disable();
        now = 64'd800_000;
        enable = 1'b1;
        hold_calc("R4");
        run_cmp(3, 1000, "R4 on boundary");
        chk(m_start == 800_000, "R4 start equals sample", m_start, 800_000);
    endtask

    // R5: future base, gates open until start
    task automatic t_future();
        do_disable();
        load(3, 0, 2_000_000);
        now = 64'd1_950_000;
        enable = 1'b1;
        hold_calc("R5");
        run_cmp(500, 1000, "R5 future base");
    endtask

    // R7: configured cycle longer, then shorter than the entry sum
    task automatic t_cfg_cycle();
        do_disable();
        load(3, 500_000, 0);
        now = 64'd3_000_000;
        enable = 1'b1;
        hold_calc("R7");
        run_cmp(1100, 1000, "R7 long cycle");
        do_disable();
        load(3, 300_000, 0);
        now = 64'd3_000_000;
        enable = 1'b1;
        hold_calc("R7");
        run_cmp(700, 1000, "R7 short cycle");
    endtask

    // R6: empty list
    task automatic t_empty();
        do_disable();
        load(0, 0, 0);
        now = 64'd5_000;
        enable = 1'b1;
        for (int k = 0; k < 60; k++) begin
            tick();
            chk(gate == 8'hFF && !pulse && idx == 0, "R6 empty list open", gate, 8'hFF);
            chk(!busy, "R6 no computation", busy, 0);
            now = now + 64'd1000;
        end
    endtask

    // R8: forward and backward jumps
    task automatic t_jump();
        do_disable();
        set_ref();
        load(3, 0, 0);
        now = 64'd1_000_000;
        enable = 1'b1;
        hold_calc("R8");
        run_cmp(500, 1000, "R8 pre-jump");
        now = now + 64'(3 * m_cyc + 12_345);
        hold_calc("R8 forward");
        run_cmp(600, 1000, "R8 after forward jump");
        now = now - 64'(2 * m_cyc + 777);
        hold_calc("R8 backward");
        run_cmp(600, 1000, "R8 after backward jump");
    endtask

    // R9: writes while enabled have no effect on the running schedule
    task automatic t_frozen();
        wr(8, 64'h01);
        wr(16, 1);
        wr(19, 100);
        run_cmp(900, 1000, "R9 writes ignored");
        do_disable();
    endtask

    initial begin
        #(20 * 150000);
        miss++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_reference();
        t_frozen();
        t_unaligned();
        t_on_boundary();
        t_future();
        t_cfg_cycle();
        t_empty();
        t_jump();
        do_disable();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

endmodule